// File: doc/BRIEF.md
# I2C Master Command-Word Sequencer

This block is the byte engine of an I2C bus master. Software, or a transmit queue, supplies 11-bit command words. Each word describes one byte of a transaction and carries flags for direction, a STOP after the byte, and a repeated START before it. The engine turns the stream of words into a sequence of bus slots: START, single data or acknowledge bits, and STOP. A separate timing unit executes these slots and reports back the level it sampled on the data line. Bytes read from the target are pushed out on a receive strobe.

A single queue can therefore describe a whole transaction of several messages, including the switch from writing to reading, with no software step between phases. The engine builds the address phase itself from a target-address input and a width select, in either 7-bit or 10-bit form. It reports a NACK with an error pulse, then discards the rest of the transaction and closes the bus cleanly. A completion pulse always follows.

Top module: `i2cseq_engine`

## Requirements
- R1: After reset the engine requests no slot, pops no word, holds no wait, and raises no event or receive strobe.
- R2: A command word holds data in [7:0], read in bit 8, STOP-after in bit 9 and repeated-START-before in bit 10. Slot kinds are 0 = START, 1 = STOP and 2 = BIT. The first word after idle produces a START, then in 7-bit mode the byte {addr[6:0], bit 8}, sent MSB first and followed by an acknowledge slot.
- R3: In 10-bit mode a write is addressed with the bytes 11110,addr[9:8],0 and then addr[7:0].
- R4: In 10-bit mode a read is addressed with 11110,addr[9:8],0, then addr[7:0], then a repeated START, then 11110,addr[9:8],1.
- R5: A write byte is sent MSB first. In its acknowledge slot the master drives 1, and a sampled 0 means ACK.
- R6: A read byte uses eight slots in which the master drives 1, assembles the sampled bits MSB first, and then drives its acknowledge. The acknowledge is 0, or 1 when the word has STOP set. The byte appears with rx_push one cycle after the ninth slot completes.
- R7: A word with bit 10 clear continues the current message with no new START or address. A word with bit 10 set inserts a START and a full address phase that uses that word's read bit.
- R8: After the byte of a word with bit 9 set, a STOP slot follows. evt_done pulses one cycle after that slot completes, and the engine returns to idle.
- R9: When the address or a write byte is NACKed, evt_err pulses. The engine then pops the remaining words up to and including the next one with STOP, issues a STOP, and only then pulses evt_done.
- R10: While a transaction is open and the command queue is empty, hold_low is high and no slot is requested.
- R11: A requested slot keeps its kind and bit unchanged until the timing unit completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_taddr | input | 10 | Target address |
| cmd_valid | input | 1 | Command queue not empty |
| cmd_word | input | 11 | Head command word (first-word fall-through) |
| cmd_pop | output | 1 | Consume head word at this edge |
| slot_req | output | 1 | Slot request to timing unit |
| slot_kind | output | 2 | 0 START, 1 STOP, 2 BIT |
| slot_bit | output | 1 | Level to drive in a BIT slot (1 = release) |
| slot_done | input | 1 | Timing unit completed the requested slot |
| slot_rbit | input | 1 | Data line level sampled in that slot |
| hold_low | output | 1 | Clock line is held low, waiting for commands |
| rx_push | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| evt_err | output | 1 | Transfer-error pulse |
| evt_done | output | 1 | Transfer-complete pulse |

## Verification
A wrong phase state shows up at the slot interface on the very next slot: a START, STOP or address bit appears where a data bit is expected, or the other way round. The bench compares every completed slot, in order, against a sequence built from the command words. A corrupted shift register or bit counter puts a wrong bit on the wire within the same byte, or pushes a wrong received byte one cycle after the acknowledge slot. Wrong flush tracking appears as a pop count that differs from the queue contents, or as evt_done arriving without the preceding evt_err.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int BYTE_W   = 8;
  localparam int CMD_W    = BYTE_W + 3;
  localparam int TADDR_W  = 10;
  localparam int STEP_W   = 2;
  localparam logic [4:0] TEN_HDR = 5'b11110;

  typedef enum logic [1:0] {
    SLOT_START = 2'd0,
    SLOT_STOP  = 2'd1,
    SLOT_BIT   = 2'd2
  } slot_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ALOAD, ST_ADDR,
    ST_DATA, ST_FETCH, ST_FLUSH, ST_STOP
  } seq_state_e;

  typedef struct packed {
    logic              rs;
    logic              stop;
    logic              rd;
    logic [BYTE_W-1:0] data;
  } cmd_word_t;
endpackage

// File: rtl/i2cseq_shifter.sv
module i2cseq_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_byte,
  input  logic         ld_rd,
  input  logic         ld_ack,
  input  logic         step,
  input  logic         rbit,
  output logic         tx_bit,
  output logic         last_slot,
  output logic [W-1:0] rx_byte
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic          ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      cnt   <= '0;
      rd_q  <= 1'b0;
      ack_q <= 1'b1;
    end else if (load) begin
      sh    <= ld_byte;
      cnt   <= '0;
      rd_q  <= ld_rd;
      ack_q <= ld_ack;
    end else if (step && !last_slot) begin
      sh  <= {sh[W-2:0], rbit};
      cnt <= cnt + 1'b1;
    end
  end

  assign last_slot = (cnt == CW'(W));
  assign tx_bit    = last_slot ? (rd_q ? ack_q : 1'b1)
                               : (rd_q ? 1'b1  : sh[W-1]);
  assign rx_byte   = sh;
endmodule

// File: rtl/i2cseq_addr_gen.sv
module i2cseq_addr_gen
  import i2cseq_pkg::*;
(
  input  logic               ten,
  input  logic [TADDR_W-1:0] taddr,
  input  logic               rd,
  input  logic [STEP_W-1:0]  step,
  output logic [BYTE_W-1:0]  abyte,
  output logic               is_rs,
  output logic               is_last
);
  always_comb begin
    abyte   = {taddr[6:0], rd};
    is_rs   = 1'b0;
    is_last = 1'b1;
    if (ten) begin
      case (step)
        2'd0: begin
          abyte   = {TEN_HDR, taddr[9:8], 1'b0};
          is_last = 1'b0;
        end
        2'd1: begin
          abyte   = taddr[7:0];
          is_last = !rd;
        end
        2'd2: begin
          abyte   = '0;
          is_rs   = 1'b1;
          is_last = 1'b0;
        end
        default: abyte = {TEN_HDR, taddr[9:8], 1'b1};
      endcase
    end
  end
endmodule

// File: rtl/i2cseq_engine.sv
module i2cseq_engine
  import i2cseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_ten_bit,
  input  logic [TADDR_W-1:0] cfg_taddr,
  input  logic               cmd_valid,
  input  logic [CMD_W-1:0]   cmd_word,
  output logic               cmd_pop,
  output logic               slot_req,
  output logic [1:0]         slot_kind,
  output logic               slot_bit,
  input  logic               slot_done,
  input  logic               slot_rbit,
  output logic               hold_low,
  output logic               rx_push,
  output logic [BYTE_W-1:0]  rx_byte,
  output logic               evt_err,
  output logic               evt_done
);
  seq_state_e          st;
  cmd_word_t           inw;
  logic [BYTE_W-1:0]   cur_data;
  logic                cur_rd;
  logic                cur_stop;
  logic [STEP_W-1:0]   step_q;

  logic [BYTE_W-1:0]   a_byte;
  logic                a_rs;
  logic                a_last;

  logic                sh_load;
  logic [BYTE_W-1:0]   sh_byte;
  logic                sh_rd;
  logic                sh_ack;
  logic                sh_tx;
  logic                sh_last;
  logic [BYTE_W-1:0]   sh_rx;
  logic                bit_step;
  logic                byte_done;

  assign inw = cmd_word_t'(cmd_word);

  i2cseq_addr_gen u_addr (
    .ten     (cfg_ten_bit),
    .taddr   (cfg_taddr),
    .rd      (cur_rd),
    .step    (step_q),
    .abyte   (a_byte),
    .is_rs   (a_rs),
    .is_last (a_last)
  );

  i2cseq_shifter #(.W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (sh_load),
    .ld_byte   (sh_byte),
    .ld_rd     (sh_rd),
    .ld_ack    (sh_ack),
    .step      (bit_step),
    .rbit      (slot_rbit),
    .tx_bit    (sh_tx),
    .last_slot (sh_last),
    .rx_byte   (sh_rx)
  );

  // slot interface, decoded from state registers only
  always_comb begin
    slot_req  = (st == ST_START) || (st == ST_ADDR) ||
                (st == ST_DATA)  || (st == ST_STOP);
    slot_kind = SLOT_BIT;
    if (st == ST_START || (st == ST_ADDR && a_rs)) slot_kind = SLOT_START;
    else if (st == ST_STOP)                        slot_kind = SLOT_STOP;
    slot_bit  = (slot_kind == SLOT_BIT) ? sh_tx : 1'b1;
    cmd_pop   = cmd_valid &&
                (st == ST_IDLE || st == ST_FETCH || st == ST_FLUSH);
    hold_low  = !cmd_valid && (st == ST_FETCH || st == ST_FLUSH);
  end

  assign bit_step  = slot_req && slot_done && (slot_kind == SLOT_BIT);
  assign byte_done = bit_step && sh_last;

  // shifter load selection
  always_comb begin
    sh_load = 1'b0;
    sh_byte = a_byte;
    sh_rd   = 1'b0;
    sh_ack  = 1'b1;
    case (st)
      ST_ALOAD: sh_load = !a_rs;
      ST_ADDR: begin
        if (byte_done && !slot_rbit && a_last) begin
          sh_load = 1'b1;
          sh_byte = cur_data;
          sh_rd   = cur_rd;
          sh_ack  = cur_stop;
        end
      end
      ST_FETCH: begin
        if (cmd_valid && !inw.rs) begin
          sh_load = 1'b1;
          sh_byte = inw.data;
          sh_rd   = inw.rd;
          sh_ack  = inw.stop;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cur_data <= '0;
      cur_rd   <= 1'b0;
      cur_stop <= 1'b0;
      step_q   <= '0;
      evt_err  <= 1'b0;
      evt_done <= 1'b0;
      rx_push  <= 1'b0;
      rx_byte  <= '0;
    end else begin
      evt_err  <= 1'b0;
      evt_done <= 1'b0;
      rx_push  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            cur_data <= inw.data;
            cur_rd   <= inw.rd;
            cur_stop <= inw.stop;
            st       <= ST_START;
          end
        end
        ST_START: begin
          if (slot_done) begin
            step_q <= '0;
            st     <= ST_ALOAD;
          end
        end
        ST_ALOAD: st <= ST_ADDR;
        ST_ADDR: begin
          if (a_rs) begin
            if (slot_done) begin
              step_q <= step_q + 1'b1;
              st     <= ST_ALOAD;
            end
          end else if (byte_done) begin
            if (slot_rbit) begin
              evt_err <= 1'b1;
              st      <= cur_stop ? ST_STOP : ST_FLUSH;
            end else if (a_last) begin
              st <= ST_DATA;
            end else begin
              step_q <= step_q + 1'b1;
              st     <= ST_ALOAD;
            end
          end
        end
        ST_DATA: begin
          if (byte_done) begin
            if (cur_rd) begin
              rx_push <= 1'b1;
              rx_byte <= sh_rx;
            end
            if (!cur_rd && slot_rbit) begin
              evt_err <= 1'b1;
              st      <= cur_stop ? ST_STOP : ST_FLUSH;
            end else begin
              st <= cur_stop ? ST_STOP : ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (cmd_valid) begin
            cur_data <= inw.data;
            cur_rd   <= inw.rd;
            cur_stop <= inw.stop;
            st       <= inw.rs ? ST_START : ST_DATA;
          end
        end
        ST_FLUSH: begin
          if (cmd_valid && inw.stop) st <= ST_STOP;
        end
        ST_STOP: begin
          if (slot_done) begin
            evt_done <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_pop,
  input logic       slot_req,
  input logic [1:0] slot_kind,
  input logic       slot_bit,
  input logic       slot_done,
  input logic       hold_low,
  input logic       rx_push,
  input logic       evt_err,
  input logic       evt_done
);
  p_kind_legal_r2: assert property (@(posedge clk) disable iff (rst)
    slot_req |-> slot_kind != 2'd3);

  p_pop_valid_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_pop |-> cmd_valid);

  p_rx_after_bit_r6: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> $past(slot_req && slot_done && slot_kind == 2'd2));

  p_done_after_stop_r8: assert property (@(posedge clk) disable iff (rst)
    evt_done |-> $past(slot_req && slot_done && slot_kind == 2'd1));

  p_err_done_apart_r9: assert property (@(posedge clk) disable iff (rst)
    !(evt_err && evt_done));

  p_hold_no_slot_r10: assert property (@(posedge clk) disable iff (rst)
    hold_low |-> !slot_req);

  p_slot_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (slot_req && !slot_done) |=>
      (slot_req && $stable(slot_kind) && $stable(slot_bit)));
endmodule

bind i2cseq_engine i2cseq_checker u_i2cseq_checker (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_pop   (cmd_pop),
  .slot_req  (slot_req),
  .slot_kind (slot_kind),
  .slot_bit  (slot_bit),
  .slot_done (slot_done),
  .hold_low  (hold_low),
  .rx_push   (rx_push),
  .evt_err   (evt_err),
  .evt_done  (evt_done)
);

// File: tb/test_i2cseq_engine.sv
module test_i2cseq_engine;
  localparam int CLK_PERIOD = 10;
  localparam int FIFO_N = 1024;
  localparam int MAXS = 1024;
  localparam int MAXW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        cfg_ten_bit = 1'b0;
  logic [9:0]  cfg_taddr = '0;
  logic        cmd_valid;
  logic [10:0] cmd_word;
  logic        cmd_pop;
  logic        slot_req;
  logic [1:0]  slot_kind;
  logic        slot_bit;
  logic        slot_done = 1'b0;
  logic        slot_rbit = 1'b1;
  logic        hold_low;
  logic        rx_push;
  logic [7:0]  rx_byte;
  logic        evt_err;
  logic        evt_done;

  i2cseq_engine i_i2cseq_engine (
    .clk(clk), .rst(rst), .cfg_ten_bit(cfg_ten_bit), .cfg_taddr(cfg_taddr),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_pop(cmd_pop),
    .slot_req(slot_req), .slot_kind(slot_kind), .slot_bit(slot_bit),
    .slot_done(slot_done), .slot_rbit(slot_rbit), .hold_low(hold_low),
    .rx_push(rx_push), .rx_byte(rx_byte), .evt_err(evt_err), .evt_done(evt_done)
  );

  // command queue model
  logic [10:0] fifo [FIFO_N];
  int wr_ptr = 0;
  int avail = 0;
  int rd_ptr = 0;
  assign cmd_valid = rd_ptr < avail;
  assign cmd_word  = (rd_ptr < FIFO_N) ? fifo[rd_ptr] : 11'd0;
  always @(posedge clk) if (!rst && cmd_pop) rd_ptr <= rd_ptr + 1;

  // expected and observed slot traces
  logic [1:0] exp_kind [MAXS];
  logic       exp_bit  [MAXS];
  logic       exp_rb   [MAXS];
  string      exp_tag  [MAXS];
  logic [1:0] got_kind [MAXS];
  logic       got_bit  [MAXS];
  int n_exp, n_got;
  logic [7:0] exp_rx [MAXW];
  logic [7:0] got_rx [MAXW];
  int n_rxe, n_rxg, exp_err;
  int n_err, n_done, err_t, done_t, cyc;

  // transaction description
  logic [10:0] tw  [MAXW];
  logic [7:0]  trd [MAXW];
  int tnw, nack_i;
  bit nack_addr;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // timing unit and observer
  always @(negedge clk) begin
    cyc++;
    if (!rst && slot_req && ($urandom_range(0, 3) != 0)) begin
      if (n_got < MAXS) begin
        got_kind[n_got] = slot_kind;
        got_bit[n_got]  = slot_bit;
      end
      slot_rbit = (n_got < n_exp) ? exp_rb[n_got] : 1'b1;
      n_got++;
      slot_done = 1'b1;
    end else begin
      slot_done = 1'b0;
      slot_rbit = 1'b1;
    end
    if (!rst && rx_push) begin
      if (n_rxg < MAXW) got_rx[n_rxg] = rx_byte;
      n_rxg++;
    end
    if (!rst && evt_err)  begin n_err++;  err_t = cyc;  end
    if (!rst && evt_done) begin n_done++; done_t = cyc; end
  end

  function automatic logic [10:0] mk(input bit rs, input bit sp,
                                     input bit rd, input logic [7:0] d);
    return {rs, sp, rd, d};
  endfunction

  task automatic add_slot(input logic [1:0] k, input logic b,
                          input logic rb, input string tag);
    exp_kind[n_exp] = k; exp_bit[n_exp] = b;
    exp_rb[n_exp] = rb;  exp_tag[n_exp] = tag;
    n_exp++;
  endtask

  task automatic add_wbyte(input logic [7:0] v, input bit nack, input string tag);
    for (int k = 7; k >= 0; k--) add_slot(2'd2, v[k], v[k], tag);
    add_slot(2'd2, 1'b1, nack, tag);
  endtask

  task automatic add_rbyte(input logic [7:0] v, input bit last, input string tag);
    for (int k = 7; k >= 0; k--) add_slot(2'd2, 1'b1, v[k], tag);
    add_slot(2'd2, last, 1'b1, tag);
  endtask

  task automatic add_addr(input bit rd, input bit nack, output bit bad);
    bad = 1'b0;
    if (!cfg_ten_bit) begin
      add_wbyte({cfg_taddr[6:0], rd}, nack, "R2");
      bad = nack;
    end else begin
      add_wbyte({5'b11110, cfg_taddr[9:8], 1'b0}, nack, rd ? "R4" : "R3");
      bad = nack;
      if (!nack) begin
        add_wbyte(cfg_taddr[7:0], 1'b0, rd ? "R4" : "R3");
        if (rd) begin
          add_slot(2'd0, 1'b1, 1'b1, "R4");
          add_wbyte({5'b11110, cfg_taddr[9:8], 1'b1}, 1'b0, "R4");
        end
      end
    end
  endtask

  task automatic build();
    int i;
    bit first, bad;
    logic [10:0] w;
    n_exp = 0; n_rxe = 0; exp_err = 0;
    i = 0; first = 1'b1; bad = 1'b0;
    while (i < tnw) begin
      w = tw[i];
      if (first || w[10]) begin
        add_slot(2'd0, 1'b1, 1'b1, first ? "R2" : "R7");
        add_addr(w[8], (i == nack_i) && nack_addr, bad);
        first = 1'b0;
      end
      if (!bad) begin
        if (w[8]) begin
          add_rbyte(trd[i], w[9], "R6");
          exp_rx[n_rxe] = trd[i];
          n_rxe++;
        end else begin
          bad = (i == nack_i) && !nack_addr;
          add_wbyte(w[7:0], bad, "R5");
        end
      end
      if (bad) begin
        exp_err = 1;
        while (!tw[i][9]) i++;
        add_slot(2'd1, 1'b1, 1'b1, "R9");
        break;
      end
      if (w[9]) begin
        add_slot(2'd1, 1'b1, 1'b1, "R8");
        break;
      end
      i++;
    end
  endtask

  task automatic run_txn(input int gap);
    int t;
    int base;
    int got_before;
    bit seen;
    bit ok;
    n_got = 0; n_rxg = 0; n_err = 0; n_done = 0;
    build();
    base = wr_ptr;
    for (int i = 0; i < tnw; i++) begin
      fifo[wr_ptr] = tw[i];
      wr_ptr++;
    end
    if (gap < 0) begin
      avail = wr_ptr;
    end else begin
      avail = base + gap;
      seen = 1'b0;
      for (int k = 0; k < 5000 && !seen; k++) begin
        @(negedge clk);
        seen = hold_low;
      end
      chk(seen, "R10", "hold_low raised on empty queue", seen, 1);
      got_before = n_got;
      ok = 1'b1;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (!hold_low || slot_req) ok = 1'b0;
      end
      chk(ok && (n_got == got_before), "R10", "wait without slots",
          n_got - got_before, 0);
      avail = wr_ptr;
    end
    t = 0;
    while (n_done == 0 && t < 30000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(n_got == n_exp, "R7", "slot count", n_got, n_exp);
    for (int s = 0; s < n_exp && s < n_got; s++) begin
      chk(got_kind[s] == exp_kind[s], exp_tag[s], $sformatf("slot %0d kind", s),
          got_kind[s], exp_kind[s]);
      if (exp_kind[s] == 2'd2)
        chk(got_bit[s] == exp_bit[s], exp_tag[s], $sformatf("slot %0d bit", s),
            got_bit[s], exp_bit[s]);
    end
    chk(n_rxg == n_rxe, "R6", "received byte count", n_rxg, n_rxe);
    for (int r = 0; r < n_rxe && r < n_rxg; r++)
      chk(got_rx[r] == exp_rx[r], "R6", "received byte", got_rx[r], exp_rx[r]);
    chk(n_done == 1, "R8", "completion pulses", n_done, 1);
    chk(n_err == exp_err, "R9", "error pulses", n_err, exp_err);
    if (exp_err != 0)
      chk(err_t < done_t, "R9", "error before completion", err_t, done_t);
    chk(rd_ptr == wr_ptr, "R9", "words popped", rd_ptr, wr_ptr);
  endtask

  task automatic gen_random();
    int nmsg, len;
    bit rd;
    tnw = 0;
    nmsg = $urandom_range(1, 3);
    for (int m = 0; m < nmsg; m++) begin
      rd  = $urandom_range(0, 1);
      len = $urandom_range(1, 3);
      for (int j = 0; j < len; j++) begin
        tw[tnw]  = mk((j == 0) ? ((m > 0) ? 1'b1 : 1'($urandom_range(0, 1))) : 1'b0,
                      1'b0, rd, 8'($urandom));
        trd[tnw] = 8'($urandom);
        tnw++;
      end
    end
    tw[tnw-1][9] = 1'b1;
    nack_i = -1;
    nack_addr = 1'b0;
    if ($urandom_range(0, 3) == 0) begin
      nack_i = $urandom_range(0, tnw - 1);
      nack_addr = (nack_i == 0 || tw[nack_i][10]) ? 1'($urandom_range(0, 1)) : 1'b0;
      if (!nack_addr && tw[nack_i][8]) nack_i = -1;
    end
    cfg_ten_bit = $urandom_range(0, 1);
    cfg_taddr   = 10'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < FIFO_N; i++) fifo[i] = '0;
    n_exp = 0; n_got = 0; cyc = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!slot_req && !cmd_pop && !hold_low && !rx_push && !evt_err && !evt_done,
        "R1", "idle outputs after reset",
        {slot_req, cmd_pop, hold_low, rx_push, evt_err, evt_done}, 0);

    // 7-bit single write
    cfg_ten_bit = 0; cfg_taddr = 10'h05A;
    tw[0] = mk(0, 1, 0, 8'hA5); tnw = 1; nack_i = -1; nack_addr = 0;
    run_txn(-1);
    // 10-bit write, two bytes
    cfg_ten_bit = 1; cfg_taddr = 10'h2C3;
    tw[0] = mk(0, 0, 0, 8'h3C); tw[1] = mk(0, 1, 0, 8'hC3); tnw = 2;
    run_txn(-1);
    // 10-bit read, two bytes, last NACKed by master
    tw[0] = mk(0, 0, 1, 8'h00); tw[1] = mk(0, 1, 1, 8'h00);
    trd[0] = 8'h81; trd[1] = 8'h7E; tnw = 2;
    run_txn(-1);
    // 7-bit write then repeated START read
    cfg_ten_bit = 0; cfg_taddr = 10'h011;
    tw[0] = mk(0, 0, 0, 8'h10); tw[1] = mk(1, 1, 1, 8'h00); trd[1] = 8'h5A; tnw = 2;
    run_txn(-1);
    // address NACK on a word that already carries STOP
    tw[0] = mk(0, 1, 0, 8'hFF); tnw = 1; nack_i = 0; nack_addr = 1;
    run_txn(-1);
    // write data NACK with flush of two more words
    tw[0] = mk(0, 0, 0, 8'h01); tw[1] = mk(0, 0, 0, 8'h02); tw[2] = mk(0, 1, 0, 8'h03);
    tnw = 3; nack_i = 0; nack_addr = 0;
    run_txn(-1);
    // queue runs dry mid-message
    nack_i = -1; nack_addr = 0;
    tw[0] = mk(0, 0, 0, 8'h6B); tw[1] = mk(0, 0, 0, 8'h94); tw[2] = mk(0, 1, 0, 8'h0F);
    tnw = 3;
    run_txn(1);

    for (int n = 0; n < 40; n++) begin
      gen_random();
      run_txn(-1);
    end

    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end
endmodule